// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block collects a set of interrupt input lines, keeps a pending bit for each internal line and decides which priority level, if any, should interrupt the core. External request pins first pass through a compile-time routing table that assigns each pin to an internal line. Each internal line is either level-type, whose pending bit simply tracks the routed input, or edge-type, whose pending bit is set by a rising edge and stays set until software clears it through a write-one-to-clear port.

The pending bits are masked by an enable register. Every internal line belongs to one priority level, and each level's membership is a parameter mask. The levels are examined from the highest configured one downwards. Only levels strictly above the core's current interrupt level are considered. The first level that owns an enabled pending line becomes the registered result. The result is driven to the core as a level number together with a request flag.

Top module: `irq_level_resolver`

## Requirements
- R1: A level-type internal line (default: even line numbers) has its pending bit equal to its routed input as sampled at the previous clock edge, so the bit is set while the input is high and cleared when it drops.
- R2: An edge-type internal line (default: odd line numbers) has its pending bit set on a rising edge of its routed input, and the bit stays set after the input falls.
- R3: When `clr_wr` is high, each edge-type line whose bit in `clr_mask` is 1 loses its pending bit at the next edge, unless a rising edge arrives on that line in the same cycle, in which case the bit stays set. The clear port has no effect on level-type lines.
- R4: When `en_wr` is high, the enable register is loaded from `en_wdata` at the next edge. Bits at or above the configured line count are ignored, and the register resets to all zeros. Only lines that are both pending and enabled take part in arbitration.
- R5: The winner is the highest level L, with NUM_LEVELS >= L > `cur_level`, whose membership mask holds an enabled pending line. In that case `pend_level` = L and `irq_req` = 1. With the default masks, lines 3k-3..3k-1 belong to level k for k = 1 to 4, and lines 12..15 belong to level 5.
- R6: When no level qualifies, `pend_level` is 0 and `irq_req` is 0. This includes the case where the only enabled pending lines sit at or below `cur_level`.
- R7: The result is registered. It reflects pending, enable and `cur_level` as they stand one edge earlier, so a change on an external pin reaches the outputs two edges later.
- R8: External pin e drives internal line EXT_MAP[e] (by default 15-e for e < 16). Pins with index at or above NUM_EXT (default 20) are ignored, and so are pins routed to an internal index at or above NUM_IRQ (default 16; this applies to pins 16 to 19 by default).
- R9: While `rst_n` is low, `pend_level` and `irq_req` are 0 and every pending and enable bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 32 | External interrupt request pins |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 32 | New enable register value |
| clr_wr | input | 1 | Write-one-to-clear strobe for edge-type pending bits |
| clr_mask | input | 32 | Bits to clear |
| cur_level | input | 3 | Current interrupt level of the core |
| pend_level | output | 3 | Winning pending level, 0 when none |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench first drives single lines of each kind. A held level line and a one-cycle pulse on an edge line show the difference between tracking and sticky pending bits. Clear writes are issued against an edge bit, against a level bit, and in the same cycle as a fresh rising edge, which shows that clearing is limited to edge-type lines and that set takes priority over clear. Lines of several levels are then made pending together while `cur_level` is stepped through and around them. This separates strict from inclusive threshold comparison and highest-first from lowest-first scanning, and unused, unrouted and out-of-range pins show the routing table is honoured. A pseudo-random run of pins, enables, clears and levels is compared every cycle against a behavioural model.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int MAX_LINES  = 32;
  localparam int MAX_LEVELS = 7;
  localparam int LVL_W      = 3;
  localparam int IDX_W      = 5;
  localparam int MAP_W      = MAX_LINES * IDX_W;
  localparam int MASKS_W    = MAX_LEVELS * MAX_LINES;

  // Default routing: pin e feeds line (n-1-e) for e < n, otherwise line e.
  function automatic logic [MAP_W-1:0] reversed_map(input int n);
    logic [MAP_W-1:0] m;
    m = '0;
    for (int e = 0; e < MAX_LINES; e++) begin
      if (e < n) m[e*IDX_W +: IDX_W] = IDX_W'(n - 1 - e);
      else       m[e*IDX_W +: IDX_W] = IDX_W'(e);
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_line_map.sv
module irq_line_map
  import irq_lvl_pkg::*;
#(
  parameter int NUM_EXT = 20,
  parameter int NUM_IRQ = 16,
  parameter logic [MAP_W-1:0] EXT_MAP = reversed_map(16)
) (
  input  logic [MAX_LINES-1:0] ext_irq,
  output logic [MAX_LINES-1:0] line_vec
);
  localparam int EXT_USED = (NUM_EXT > MAX_LINES) ? MAX_LINES : NUM_EXT;

  for (genvar j = 0; j < MAX_LINES; j++) begin : g_line
    if (j < NUM_IRQ) begin : g_live
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int e = 0; e < EXT_USED; e++) begin
          if (EXT_MAP[e*IDX_W +: IDX_W] == IDX_W'(j)) hit = hit | ext_irq[e];
        end
      end
      assign line_vec[j] = hit;
    end else begin : g_dead
      assign line_vec[j] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_lvl_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter logic [MAX_LINES-1:0] EDGE_MASK = 32'h0000_AAAA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MAX_LINES-1:0] line_vec,
  input  logic                 clr_wr,
  input  logic [MAX_LINES-1:0] clr_mask,
  input  logic                 en_wr,
  input  logic [MAX_LINES-1:0] en_wdata,
  output logic [MAX_LINES-1:0] pend_q,
  output logic [MAX_LINES-1:0] en_q
);
  localparam logic [MAX_LINES-1:0] LIVE_MASK =
    (NUM_IRQ >= MAX_LINES) ? {MAX_LINES{1'b1}} : ((MAX_LINES'(1) << NUM_IRQ) - MAX_LINES'(1));
  localparam logic [MAX_LINES-1:0] EDGE_LIVE = EDGE_MASK & LIVE_MASK;
  localparam logic [MAX_LINES-1:0] LVL_LIVE  = ~EDGE_MASK & LIVE_MASK;

  logic [MAX_LINES-1:0] line_q;
  logic [MAX_LINES-1:0] rise;
  logic [MAX_LINES-1:0] clr_eff;
  logic [MAX_LINES-1:0] edge_d;
  logic [MAX_LINES-1:0] pend_d;
  logic [MAX_LINES-1:0] en_d;

  always_comb begin
    rise    = line_vec & ~line_q;
    clr_eff = clr_wr ? clr_mask : '0;
    // A fresh rising edge wins over a clear in the same cycle.
    edge_d  = rise | (pend_q & ~clr_eff);
    pend_d  = (edge_d & EDGE_LIVE) | (line_vec & LVL_LIVE);
    en_d    = en_wdata & LIVE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      line_q <= line_vec & LIVE_MASK;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_d;
  end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LEVELS = 5,
  parameter logic [MASKS_W-1:0] LEVEL_MASKS = '0
) (
  input  logic [MAX_LINES-1:0] cand,
  input  logic [LVL_W-1:0]     cur_level,
  output logic [LVL_W-1:0]     win_level
);
  logic [MAX_LEVELS:1] lvl_hit;

  for (genvar lv = 1; lv <= MAX_LEVELS; lv++) begin : g_lvl
    if (lv <= NUM_LEVELS) begin : g_used
      assign lvl_hit[lv] = (|(cand & LEVEL_MASKS[(lv-1)*MAX_LINES +: MAX_LINES]))
                           && (LVL_W'(lv) > cur_level);
    end else begin : g_unused
      assign lvl_hit[lv] = 1'b0;
    end
  end

  always_comb begin
    win_level = '0;
    for (int lv = 1; lv <= MAX_LEVELS; lv++) begin
      if (lvl_hit[lv]) win_level = LVL_W'(lv);
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_lvl_pkg::*;
#(
  parameter int NUM_IRQ    = 16,
  parameter int NUM_EXT    = 20,
  parameter int NUM_LEVELS = 5,
  parameter logic [MAX_LINES-1:0] EDGE_MASK = 32'h0000_AAAA,
  parameter logic [MAP_W-1:0]     EXT_MAP   = reversed_map(16),
  parameter logic [MASKS_W-1:0]   LEVEL_MASKS = {32'h0, 32'h0, 32'h0000_F000,
                                                 32'h0000_0E00, 32'h0000_01C0,
                                                 32'h0000_0038, 32'h0000_0007}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ext_irq,
  input  logic        en_wr,
  input  logic [31:0] en_wdata,
  input  logic        clr_wr,
  input  logic [31:0] clr_mask,
  input  logic [2:0]  cur_level,
  output logic [2:0]  pend_level,
  output logic        irq_req
);
  logic [MAX_LINES-1:0] line_vec;
  logic [MAX_LINES-1:0] pend_q;
  logic [MAX_LINES-1:0] en_q;
  logic [LVL_W-1:0]     win_level;
  logic [LVL_W-1:0]     lvl_d;
  logic                 req_d;

  irq_line_map #(.NUM_EXT(NUM_EXT), .NUM_IRQ(NUM_IRQ), .EXT_MAP(EXT_MAP)) u_map (
    .ext_irq (ext_irq),
    .line_vec(line_vec)
  );

  irq_pend_reg #(.NUM_IRQ(NUM_IRQ), .EDGE_MASK(EDGE_MASK)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_vec(line_vec),
    .clr_wr  (clr_wr),
    .clr_mask(clr_mask),
    .en_wr   (en_wr),
    .en_wdata(en_wdata),
    .pend_q  (pend_q),
    .en_q    (en_q)
  );

  irq_level_pick #(.NUM_LEVELS(NUM_LEVELS), .LEVEL_MASKS(LEVEL_MASKS)) u_pick (
    .cand     (pend_q & en_q),
    .cur_level(cur_level),
    .win_level(win_level)
  );

  always_comb begin
    lvl_d = win_level;
    req_d = (win_level != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_level <= '0;
      irq_req    <= 1'b0;
    end else begin
      pend_level <= lvl_d;
      irq_req    <= req_d;
    end
  end
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk
  import irq_lvl_pkg::*;
#(
  parameter int NUM_IRQ    = 16,
  parameter int NUM_LEVELS = 5,
  parameter logic [MAX_LINES-1:0] EDGE_MASK = 32'h0000_AAAA
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cur_level,
  input logic [2:0]           pend_level,
  input logic                 irq_req,
  input logic                 clr_wr,
  input logic [31:0]          clr_mask,
  input logic [MAX_LINES-1:0] line_vec,
  input logic [MAX_LINES-1:0] pend_q
);
  a_r5_above_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_level > $past(cur_level)));

  a_r5_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend_level) <= NUM_LEVELS);

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (pend_level == 3'd0));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      a_r2_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && !(clr_wr && clr_mask[i])) |=> pend_q[i]);
      a_r3_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[i] && !line_vec[i]) |=> !pend_q[i]);
    end else begin : g_lvl
      a_r1_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_q[i] == $past(line_vec[i])));
    end
  end
endmodule

bind irq_level_resolver irq_level_resolver_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_LEVELS(NUM_LEVELS), .EDGE_MASK(EDGE_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_level(cur_level), .pend_level(pend_level),
  .irq_req(irq_req), .clr_wr(clr_wr), .clr_mask(clr_mask),
  .line_vec(line_vec), .pend_q(pend_q)
);

// File: tb/tb_irq_level_resolver.sv
`timescale 1ns/1ps
module tb_irq_level_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ext_irq;
  logic        en_wr;
  logic [31:0] en_wdata;
  logic        clr_wr;
  logic [31:0] clr_mask;
  logic [2:0]  cur_level;
  logic [2:0]  pend_level;
  logic        irq_req;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string ph      = "R9";

  // Behavioural reference state
  logic [31:0] m_pend, m_en, m_prev;
  int          m_lvl;
  bit          m_req;

  always #2.5 clk = ~clk;

  irq_level_resolver dut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .en_wr(en_wr), .en_wdata(en_wdata),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .cur_level(cur_level),
    .pend_level(pend_level), .irq_req(irq_req)
  );

  // R8: pin e < 16 feeds line 15-e; every other pin reaches nothing.
  function automatic logic [31:0] route(input logic [31:0] pins);
    logic [31:0] l = '0;
    for (int e = 0; e < 16; e++) if (pins[e]) l[15-e] = 1'b1;
    return l;
  endfunction

  // R5: level of each of the 16 lines under the default masks.
  function automatic int level_of(input int i);
    return (i < 12) ? (i / 3 + 1) : 5;
  endfunction

  function automatic int pick(input logic [31:0] cand, input int cur);
    int best = 0;
    for (int i = 0; i < 16; i++)
      if (cand[i] && level_of(i) > cur && level_of(i) > best) best = level_of(i);
    return best;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_prev = '0; m_lvl = 0; m_req = 0;
    end else begin
      logic [31:0] l, np;
      m_lvl = pick(m_pend & m_en, int'(cur_level));
      m_req = (m_lvl != 0);
      l  = route(ext_irq);
      np = '0;
      for (int i = 0; i < 16; i++) begin
        if (i % 2 == 1) np[i] = (l[i] & ~m_prev[i]) | (m_pend[i] & ~(clr_wr & clr_mask[i]));
        else            np[i] = l[i];
      end
      m_prev = l;
      m_pend = np;
      if (en_wr) m_en = en_wdata & 32'h0000_FFFF;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    check({ph, " level"}, int'(pend_level), m_lvl);
    check({ph, " req"},   int'(irq_req),    int'(m_req));
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic write_en(input logic [31:0] v);
    en_wr = 1'b1; en_wdata = v; tick(); en_wr = 1'b0;
  endtask

  task automatic clear(input logic [31:0] v);
    clr_wr = 1'b1; clr_mask = v; tick(); clr_wr = 1'b0; clr_mask = '0;
  endtask

  initial begin
    rst_n = 1'b0; ext_irq = '0; en_wr = 0; en_wdata = '0;
    clr_wr = 0; clr_mask = '0; cur_level = '0;
    repeat (3) @(negedge clk);
    check("R9 reset level", int'(pend_level), 0);
    check("R9 reset req",   int'(irq_req),    0);
    rst_n = 1'b1;
    ph = "R9"; tick();

    ph = "R4"; write_en(32'hFFFF_FFFF); tick();
    check("R4 nothing pending", int'(pend_level), 0);

    ph = "R1"; ext_irq[15] = 1'b1; tick();
    check("R7 one edge after pin", int'(pend_level), 0);
    tick();
    check("R1 level line pending", int'(pend_level), 1);
    ext_irq[15] = 1'b0; ticks(2);
    check("R1 level line dropped", int'(pend_level), 0);

    ph = "R2"; ext_irq[14] = 1'b1; tick(); ext_irq[14] = 1'b0; ticks(2);
    check("R2 edge line sticky", int'(pend_level), 1);
    ticks(3);
    check("R2 edge line still set", int'(irq_req), 1);

    ph = "R3"; ext_irq[15] = 1'b1; ticks(2);
    clear(32'h0000_0003); tick();
    check("R3 level bit unaffected", int'(pend_level), 1);
    ext_irq[15] = 1'b0; ticks(2);
    check("R3 edge bit cleared", int'(pend_level), 0);
    ext_irq[14] = 1'b1; clear(32'h0000_0002); ext_irq[14] = 1'b0; tick();
    check("R3 rise beats clear", int'(pend_level), 1);
    clear(32'h0000_0002); tick();
    check("R3 cleared after", int'(pend_level), 0);

    ph = "R5"; ext_irq[3] = 1'b1; ext_irq[15] = 1'b1; ticks(2);
    check("R5 highest level wins", int'(pend_level), 5);
    cur_level = 3'd4; tick();
    check("R5 above threshold", int'(pend_level), 5);
    ph = "R6"; cur_level = 3'd5; tick();
    check("R6 at threshold masked", int'(irq_req), 0);
    cur_level = 3'd0; ext_irq[3] = 1'b0; ticks(2);
    ph = "R6"; cur_level = 3'd1; tick();
    check("R6 equal level excluded", int'(pend_level), 0);
    ph = "R5"; ext_irq[9] = 1'b1; ticks(2);
    check("R5 mid level above cur", int'(pend_level), 3);
    cur_level = 3'd0; tick();

    ph = "R4"; write_en(32'h0000_FFBF); tick();
    check("R4 disabled line ignored", int'(pend_level), 1);
    ext_irq = '0; write_en(32'hFFFF_FFFF); ticks(2);
    check("R4 empty", int'(pend_level), 0);

    ph = "R8"; ext_irq = 32'hFFFF_0000; ticks(3);
    check("R8 unrouted pins ignored", int'(irq_req), 0);
    ext_irq = 32'h0001_0001; ticks(2);
    check("R8 pin0 routes to line15", int'(pend_level), 5);
    ext_irq = '0; clear(32'h0000_FFFF); tick();

    ph = "R5";
    begin
      logic [31:0] lf = 32'h1ACE_B00C;
      for (int k = 0; k < 400; k++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        ext_irq   = lf & {16'h0000, lf[15:0] ^ lf[31:16]};
        cur_level = lf[7:5];
        en_wr     = (lf[12:10] == 3'd0); en_wdata = {lf[3:0], lf[31:4]};
        clr_wr    = (lf[20:18] == 3'd1); clr_mask = {lf[15:0], lf[31:16]};
        tick();
      end
      en_wr = 0; clr_wr = 0;
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule